// File: doc/BRIEF.md
# Debug TAP scan chain selector

This block is a debug test access port. It follows the standard sixteen-state TAP state machine, clocked by `tck`. It holds a 5-bit instruction register and a 5-bit chain-number register. The current instruction picks which data register sits between `tdi` and `tdo`. The choices are the chain-number register, a 32-bit identification register, a 1-bit bypass stage, or one of the downstream debug chains.

When a chain-access instruction is active, the block drives three one-hot strobe buses toward the debug chains: capture, shift and update. It also drives the active chain number and a flag that tells a write access from a read access. A separate force instruction makes chain 4 the active chain for data scans. The stored chain number is left as it was, so reloading a chain-access instruction returns to the previously selected chain.

For chains 4 and 5, entry into Run-Test/Idle under a chain-access instruction issues a one-cycle execute strobe toward the core. Two other instructions raise halt and restart request levels while they are held in the instruction register.

Top module: `dbg_tap_chainsel`

## Requirements
- R1: Reset state. Low `trst_n`, or five consecutive TCK rising edges with `tms` high, puts the TAP in Test-Logic-Reset. In that state the instruction becomes the identification code and the stored chain number becomes 0.
- R2: Capture-IR loads 5'b00001. Shift-IR shifts least significant bit first, so the first five `tdo` bits read back as the value 1.
- R3: Instruction codes are: write access 5'b00000, chain number 5'b00010, restart 5'b00100, halt 5'b01000, read access 5'b01100, force chain 4 5'b11101, identification 5'b11110, bypass 5'b11111. A new instruction takes effect only on the falling TCK edge in Update-IR. It is unchanged while in Pause-IR.
- R4: Under the identification instruction, a data scan shifts out the 32-bit `IDCODE_VAL`, least significant bit first.
- R5: Bypass is a single stage that captures 0. Every code not listed in R3, and also halt and restart, select bypass, so `tdo` repeats `tdi` one clock later.
- R6: Under the chain-number instruction, the 5-bit data register captures 5'h10. A shifted-in number reaches `chain_sel` only at the falling edge in Update-DR. It is unchanged in Shift-DR and Pause-DR.
- R7: While the force instruction is held, `chain_sel` reads 4 and the stored chain number is kept. After a chain-access instruction is loaded, `chain_sel` returns to the stored number.
- R8: Under read access, write access or force, bit k of `chain_capture`, `chain_shift` and `chain_update` is high only in Capture-DR, Shift-DR and Update-DR respectively, with k the active chain. Data scans return `chain_tdo_i[k]`. A chain number at or above `NUM_CHAINS` gives no strobe and reads 0.
- R9: `exec_strobe` is high for exactly the first Run-Test/Idle cycle after entry. It requires the active chain to be 4 or 5 and the instruction to be read access, write access or force. Chain 0 gives no strobe, and staying in Run-Test/Idle gives no repeat.
- R10: From Pause-IR, the TMS sequence 1,1,1,1,0,0 passes Exit2-IR, Update-IR, Select-DR, Select-IR and Capture-IR, and reaches Shift-IR without entering Run-Test/Idle.
- R11: `tdo` changes only on the falling TCK edge. Outside Shift-IR and Shift-DR, `tdo_en` is low and `tdo` is held at 0.
- R12: `halt_req` and `restart_req` are high while the instruction holds halt and restart respectively. `ext_mode` is high while it holds write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in, also fed to the debug chains |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while a shift state drives `tdo` |
| chain_tdo_i | input | NUM_CHAINS | Serial outputs of the debug chains |
| chain_sel | output | 5 | Active chain number |
| chain_capture | output | NUM_CHAINS | One-hot capture strobe |
| chain_shift | output | NUM_CHAINS | One-hot shift strobe |
| chain_update | output | NUM_CHAINS | One-hot update strobe |
| ext_mode | output | 1 | High when the access is a write into the chain |
| exec_strobe | output | 1 | Execute request on Run-Test/Idle entry |
| halt_req | output | 1 | Halt instruction held |
| restart_req | output | 1 | Restart instruction held |

## Verification
The hardest situations to reach from the pins are those where the two kinds of chain selection meet while the state machine avoids Run-Test/Idle. Examples are a chain-number change seen in the middle of a paused scan, and a Pause-IR to Shift-IR detour with an execute-capable chain selected. The stimulus drives those paths step by step with explicit TMS sequences. It counts execute strobes over each path, and then confirms that the next real entry into Run-Test/Idle does fire. Random chain numbers, random unused instruction codes and random bypass data fill in around these directed walks.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;
    localparam int IR_W = 5;
    localparam int CH_W = 5;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_WRACC   = 5'b00000;
    localparam logic [IR_W-1:0] OP_CHNUM   = 5'b00010;
    localparam logic [IR_W-1:0] OP_RESTART = 5'b00100;
    localparam logic [IR_W-1:0] OP_HALT    = 5'b01000;
    localparam logic [IR_W-1:0] OP_RDACC   = 5'b01100;
    localparam logic [IR_W-1:0] OP_FORCE4  = 5'b11101;
    localparam logic [IR_W-1:0] OP_IDENT   = 5'b11110;
    localparam logic [IR_W-1:0] OP_BYPASS  = 5'b11111;

    localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 5'b00001;
    localparam logic [CH_W-1:0] CN_CAPTURE_VAL = 5'h10;
    localparam logic [CH_W-1:0] FORCED_CHAIN   = 5'd4;
    localparam logic [CH_W-1:0] EXEC_CHAIN_A   = 5'd4;
    localparam logic [CH_W-1:0] EXEC_CHAIN_B   = 5'd5;

    typedef enum logic [1:0] {DR_CHNUM, DR_IDENT, DR_CHAIN, DR_BYP} dr_sel_e;
endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_d
);
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  state_d = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  state_d = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    // R1
    tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state_q == ST_RESET));
endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
    import dbg_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state_q,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so
);
    typedef struct packed { logic [IR_W-1:0] sr; } ir_pos_t;
    typedef struct packed { logic [IR_W-1:0] ir; } ir_neg_t;

    ir_pos_t pos_d, pos_q;
    ir_neg_t neg_d, neg_q;

    always_comb begin
        pos_d = pos_q;
        neg_d = neg_q;
        if (state_q == ST_CAP_IR)     pos_d.sr = IR_CAPTURE_VAL;
        else if (state_q == ST_SH_IR) pos_d.sr = {tdi, pos_q.sr[IR_W-1:1]};
        if (state_q == ST_RESET)      neg_d.ir = OP_IDENT;
        else if (state_q == ST_UPD_IR) neg_d.ir = pos_q.sr;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) pos_q <= '{sr: IR_CAPTURE_VAL};
        else         pos_q <= pos_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) neg_q <= '{ir: OP_IDENT};
        else         neg_q <= neg_d;
    end

    assign ir_q  = neg_q.ir;
    assign ir_so = pos_q.sr[0];

    // R3
    ir_update_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(ir_q) |-> (state_q == ST_UPD_IR || state_q == ST_RESET));
endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
    import dbg_tap_pkg::*;
#(
    parameter int          NUM_CHAINS = 8,
    parameter logic [31:0] IDCODE_VAL = 32'h1234_5679
) (
    input  logic                  tck,
    input  logic                  trst_n,
    input  logic                  tdi,
    input  tap_state_e            state_q,
    input  logic [IR_W-1:0]       ir_q,
    input  logic [NUM_CHAINS-1:0] chain_tdo_i,
    output logic [CH_W-1:0]       active_chain,
    output logic                  chain_op,
    output logic                  dr_so
);
    localparam int PAD_W = 1 << CH_W;

    typedef struct packed {
        logic [CH_W-1:0] cn_sr;
        logic [ID_W-1:0] id_sr;
        logic            byp;
    } dr_pos_t;
    typedef struct packed { logic [CH_W-1:0] chain; } dr_neg_t;

    dr_pos_t pos_d, pos_q;
    dr_neg_t neg_d, neg_q;
    dr_sel_e sel;
    logic [PAD_W-1:0] tdo_pad;

    always_comb begin
        unique case (ir_q)
            OP_CHNUM:                     sel = DR_CHNUM;
            OP_IDENT:                     sel = DR_IDENT;
            OP_RDACC, OP_WRACC, OP_FORCE4: sel = DR_CHAIN;
            default:                      sel = DR_BYP;
        endcase
    end

    always_comb begin
        pos_d = pos_q;
        neg_d = neg_q;
        if (state_q == ST_CAP_DR) begin
            unique case (sel)
                DR_CHNUM: pos_d.cn_sr = CN_CAPTURE_VAL;
                DR_IDENT: pos_d.id_sr = IDCODE_VAL;
                DR_BYP:   pos_d.byp   = 1'b0;
                default:  ;
            endcase
        end else if (state_q == ST_SH_DR) begin
            unique case (sel)
                DR_CHNUM: pos_d.cn_sr = {tdi, pos_q.cn_sr[CH_W-1:1]};
                DR_IDENT: pos_d.id_sr = {tdi, pos_q.id_sr[ID_W-1:1]};
                DR_BYP:   pos_d.byp   = tdi;
                default:  ;
            endcase
        end
        if (state_q == ST_RESET)                              neg_d.chain = '0;
        else if (state_q == ST_UPD_DR && sel == DR_CHNUM)     neg_d.chain = pos_q.cn_sr;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) pos_q <= '0;
        else         pos_q <= pos_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) neg_q <= '0;
        else         neg_q <= neg_d;
    end

    assign active_chain = (ir_q == OP_FORCE4) ? FORCED_CHAIN : neg_q.chain;
    assign chain_op     = (sel == DR_CHAIN);
    assign tdo_pad      = PAD_W'(chain_tdo_i);

    always_comb begin
        unique case (sel)
            DR_CHNUM: dr_so = pos_q.cn_sr[0];
            DR_IDENT: dr_so = pos_q.id_sr[0];
            DR_CHAIN: dr_so = tdo_pad[active_chain];
            default:  dr_so = pos_q.byp;
        endcase
    end

    // R6
    chain_update_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(neg_q.chain) |-> (state_q == ST_UPD_DR || state_q == ST_RESET));
    // R7
    force_keeps_chain_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_q == OP_FORCE4) |-> $stable(neg_q.chain));
endmodule

// File: rtl/dbg_tap_chainsel.sv
module dbg_tap_chainsel
    import dbg_tap_pkg::*;
#(
    parameter int          NUM_CHAINS = 8,
    parameter logic [31:0] IDCODE_VAL = 32'h1234_5679
) (
    input  logic                  tck,
    input  logic                  trst_n,
    input  logic                  tms,
    input  logic                  tdi,
    output logic                  tdo,
    output logic                  tdo_en,
    input  logic [NUM_CHAINS-1:0] chain_tdo_i,
    output logic [4:0]            chain_sel,
    output logic [NUM_CHAINS-1:0] chain_capture,
    output logic [NUM_CHAINS-1:0] chain_shift,
    output logic [NUM_CHAINS-1:0] chain_update,
    output logic                  ext_mode,
    output logic                  exec_strobe,
    output logic                  halt_req,
    output logic                  restart_req
);
    typedef struct packed { logic exec; } top_pos_t;
    typedef struct packed { logic tdo; logic en; } top_neg_t;

    tap_state_e      state_q, state_d;
    logic [IR_W-1:0] ir_q;
    logic            ir_so, dr_so, chain_op;
    logic [CH_W-1:0] active_chain;
    top_pos_t        pos_d, pos_q;
    top_neg_t        neg_d, neg_q;

    dbg_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state_q(state_q), .state_d(state_d)
    );

    dbg_tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state_q(state_q), .ir_q(ir_q), .ir_so(ir_so)
    );

    dbg_tap_dr #(.NUM_CHAINS(NUM_CHAINS), .IDCODE_VAL(IDCODE_VAL)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state_q(state_q), .ir_q(ir_q),
        .chain_tdo_i(chain_tdo_i), .active_chain(active_chain), .chain_op(chain_op),
        .dr_so(dr_so)
    );

    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_strobe
        logic hit;
        assign hit              = chain_op && (active_chain == CH_W'(k));
        assign chain_capture[k] = hit && (state_q == ST_CAP_DR);
        assign chain_shift[k]   = hit && (state_q == ST_SH_DR);
        assign chain_update[k]  = hit && (state_q == ST_UPD_DR);
    end

    always_comb begin
        pos_d.exec = (state_d == ST_IDLE) && (state_q != ST_IDLE) && chain_op &&
                     (active_chain == EXEC_CHAIN_A || active_chain == EXEC_CHAIN_B);
        neg_d.en   = (state_q == ST_SH_DR) || (state_q == ST_SH_IR);
        neg_d.tdo  = (state_q == ST_SH_IR) ? ir_so :
                     (state_q == ST_SH_DR) ? dr_so : 1'b0;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) pos_q <= '0;
        else         pos_q <= pos_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) neg_q <= '0;
        else         neg_q <= neg_d;
    end

    assign tdo         = neg_q.tdo;
    assign tdo_en      = neg_q.en;
    assign exec_strobe = pos_q.exec;
    assign chain_sel   = active_chain;
    assign ext_mode    = (ir_q == OP_WRACC);
    assign halt_req    = (ir_q == OP_HALT);
    assign restart_req = (ir_q == OP_RESTART);

    // R9
    exec_on_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
        exec_strobe |-> (state_q == ST_IDLE && $past(state_q) != ST_IDLE));
    // R8
    capture_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0(chain_capture) && $onehot0(chain_shift) && $onehot0(chain_update));
    // R11
    tdo_en_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state_q == ST_SH_DR || state_q == ST_SH_IR));
endmodule

// File: tb/sim_dbg_tap_chainsel.sv
`timescale 1ns/100ps
module sim_dbg_tap_chainsel;
    localparam int          NCH   = 8;
    localparam logic [31:0] IDV   = 32'h1234_5679;
    localparam logic [7:0]  PAT   = 8'b1011_0010;
    localparam logic [4:0]  C_WR  = 5'b00000, C_CN = 5'b00010, C_RS = 5'b00100,
                            C_HT  = 5'b01000, C_RD = 5'b01100, C_F4 = 5'b11101,
                            C_ID  = 5'b11110, C_BP = 5'b11111;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en, ext_mode, exec_strobe, halt_req, restart_req;
    logic [NCH-1:0] chain_tdo_i = PAT;
    logic [NCH-1:0] chain_capture, chain_shift, chain_update;
    logic [4:0] chain_sel;

    int errors = 0, checks = 0, exec_cnt = 0;
    bit done = 0;
    logic s_tdo;
    logic [NCH-1:0] cap_or, sh_or, up_or;

    always #2 tck = ~tck;

    dbg_tap_chainsel #(.NUM_CHAINS(NCH), .IDCODE_VAL(IDV)) u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .chain_tdo_i(chain_tdo_i), .chain_sel(chain_sel), .chain_capture(chain_capture),
        .chain_shift(chain_shift), .chain_update(chain_update), .ext_mode(ext_mode),
        .exec_strobe(exec_strobe), .halt_req(halt_req), .restart_req(restart_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        @(negedge tck); #1;
        s_tdo = tdo;
        if (exec_strobe) exec_cnt++;
        cap_or |= chain_capture; sh_or |= chain_shift; up_or |= chain_update;
        tms = m; tdi = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic scan_ir(input logic [4:0] code, input bit pause, output logic [4:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) begin
            step(i == 4, code[i]); cap[i] = s_tdo;
        end
        if (pause) step(0, 0);
        else begin step(1, 0); step(0, 0); end
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]); dout[i] = s_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic set_chain(input logic [4:0] c);
        logic [4:0] cp; logic [63:0] o;
        scan_ir(C_CN, 0, cp);
        scan_dr(5, 64'(c), o);
    endtask

    task automatic tms_reset();
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
    endtask

    function automatic bit listed(input logic [4:0] c);
        return c inside {C_WR, C_CN, C_RS, C_HT, C_RD, C_F4, C_ID, C_BP};
    endfunction

    function automatic logic [63:0] exp_byp(input logic [15:0] d);
        return 64'({d, 1'b0});
    endfunction

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] cap, v, w, c;
        logic [63:0] o;
        logic [15:0] bd;
        int unsigned sd;
        sd = $urandom(32'd2024);
        cap_or = '0; sh_or = '0; up_or = '0;
        repeat (3) @(negedge tck);
        #1 trst_n = 1'b1;
        step(0, 0);
        // R1 / R11: reset state
        chk("R1 chain_sel after trst", 64'(chain_sel), 0);
        chk("R11 tdo_en outside shift", 64'(tdo_en), 0);
        chk("R11 tdo held 0", 64'(tdo), 0);
        idle(1);
        scan_dr(32, 64'hFFFF_FFFF, o);
        chk("R1 default instruction is ident", o, 64'(IDV));

        // R2 / R4
        scan_ir(C_ID, 0, cap);
        chk("R2 IR capture", 64'(cap), 1);
        scan_dr(32, 0, o);
        chk("R4 ident value", o, 64'(IDV));

        // R11: tdo changes only on the falling edge
        idle(1);
        step(1, 0); step(0, 0); step(0, 0); step(0, 0);
        @(posedge tck); #0.5;
        chk("R11 tdo steady over rising edge", 64'(tdo), 64'(IDV[0]));
        chk("R11 tdo_en in shift", 64'(tdo_en), 1);
        @(negedge tck); #0.5;
        chk("R11 tdo next bit after falling edge", 64'(tdo), 64'(IDV[1]));
        tms_reset();

        // R5: bypass with explicit and random unused codes
        bd = 16'($urandom);
        scan_ir(C_BP, 0, cap);
        scan_dr(17, 64'(bd), o);
        chk("R5 bypass code", o, exp_byp(bd));
        for (int k = 0; k < 4; k++) begin
            do c = 5'($urandom); while (listed(c));
            bd = 16'($urandom);
            scan_ir(c, 0, cap);
            scan_dr(17, 64'(bd), o);
            chk("R5 unused code acts as bypass", o, exp_byp(bd));
        end

        // R12 / R3 / R5: halt held only after Update-IR
        scan_ir(C_HT, 1, cap);
        step(0, 0);
        chk("R3 no effect in Pause-IR", 64'(halt_req), 0);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        chk("R12 halt_req", 64'(halt_req), 1);
        bd = 16'($urandom);
        scan_dr(17, 64'(bd), o);
        chk("R5 halt selects bypass", o, exp_byp(bd));
        scan_ir(C_RS, 0, cap);
        chk("R12 restart_req", 64'({restart_req, halt_req}), 2);

        // R6: capture pattern and update timing, random numbers
        for (int k = 0; k < 6; k++) begin
            v = 5'($urandom);
            scan_ir(C_CN, 0, cap);
            scan_dr(5, 64'(v), o);
            chk("R6 chain register capture", o, 64'h10);
            step(0, 0);
            chk("R6 chain number after update", 64'(chain_sel), 64'(v));
        end
        v = 5'd3; w = 5'd12;
        set_chain(v);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(i == 4, w[i]);
        step(0, 0); step(0, 0);
        chk("R6 unchanged in Pause-DR", 64'(chain_sel), 64'(v));
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        chk("R6 new number after Update-DR", 64'(chain_sel), 64'(w));

        // R7: force instruction
        set_chain(5'd2);
        scan_ir(C_F4, 0, cap);
        chk("R7 forced chain", 64'(chain_sel), 4);
        scan_ir(C_RD, 0, cap);
        chk("R7 stored chain restored", 64'(chain_sel), 2);
        chk("R12 ext_mode low under read", 64'(ext_mode), 0);

        // R8: strobes and chain data
        for (int k = 0; k < 10; k++) begin
            c = (k == 9) ? 5'd9 : 5'(k);
            set_chain(c);
            scan_ir(C_RD, 0, cap);
            idle(1);
            cap_or = '0; sh_or = '0; up_or = '0;
            scan_dr(8, 0, o);
            chk("R8 chain read data", o, (c < NCH && PAT[c[2:0]]) ? 64'hFF : 64'h0);
            chk("R8 capture strobe", 64'(cap_or), (c < NCH) ? 64'(1 << c) : 0);
            chk("R8 shift strobe", 64'(sh_or), (c < NCH) ? 64'(1 << c) : 0);
            chk("R8 update strobe", 64'(up_or), (c < NCH) ? 64'(1 << c) : 0);
        end
        scan_ir(C_ID, 0, cap);
        idle(1);
        cap_or = '0; sh_or = '0; up_or = '0;
        scan_dr(32, 0, o);
        chk("R8 no strobes under ident", 64'({cap_or, sh_or, up_or}), 0);

        // R9: execute strobe
        set_chain(5'd5);
        scan_ir(C_WR, 0, cap);
        chk("R12 ext_mode high under write", 64'(ext_mode), 1);
        idle(2); exec_cnt = 0;
        scan_dr(8, 64'hA5, o); idle(6);
        chk("R9 exec once on chain 5 write", 64'(exec_cnt), 1);
        set_chain(5'd0);
        scan_ir(C_WR, 0, cap);
        idle(2); exec_cnt = 0;
        scan_dr(8, 64'hA5, o); idle(3);
        chk("R9 no exec on chain 0", 64'(exec_cnt), 0);
        set_chain(5'd4);
        scan_ir(C_RD, 0, cap);
        idle(2); exec_cnt = 0;
        scan_dr(8, 0, o); idle(3);
        chk("R9 exec on chain 4 read", 64'(exec_cnt), 1);
        set_chain(5'd0);
        scan_ir(C_F4, 0, cap);
        idle(2); exec_cnt = 0;
        scan_dr(8, 0, o); idle(3);
        chk("R9 exec under force", 64'(exec_cnt), 1);

        // R10: Pause-IR to Shift-IR without Run-Test/Idle
        set_chain(5'd5);
        scan_ir(C_RD, 1, cap);
        exec_cnt = 0;
        step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) begin
            step(i == 4, C_RD[i]); cap[i] = s_tdo;
        end
        step(1, 0);
        chk("R10 reached Shift-IR", 64'(cap), 1);
        chk("R10 no exec on detour", 64'(exec_cnt), 0);
        step(0, 0); step(0, 0);
        chk("R9 exec on later entry", 64'(exec_cnt), 1);

        // R1: five TMS-high clocks
        set_chain(5'd7);
        scan_ir(C_HT, 0, cap);
        tms_reset();
        chk("R1 chain cleared by tms reset", 64'(chain_sel), 0);
        chk("R1 halt cleared by tms reset", 64'(halt_req), 0);
        scan_dr(32, 0, o);
        chk("R1 ident after tms reset", o, 64'(IDV));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule